// File: doc/BRIEF.md
# Vector-Splitting Instruction Queue

This block is an instruction queue that holds scalar operations and vector operations side by side. A vector operation enters as one entry carrying an opcode, a destination and a source base register, an element count and a per-element predicate mask. The queue never issues a vector entry. When one reaches the head, the block runs a split pass. The pass walks the vector from its next element index and writes up to N enabled elements back into the same storage as ordinary scalar entries. It then appends the shortened vector behind them, or drops it once nothing is left. Scalar entries leave through a valid/ready port, one per handshake.

Each element op carries the opcode of its vector and register numbers equal to the base plus the element index, modulo the register-file size. It also carries the element index, so downstream logic can see where it came from. The input side is throttled so that a split pass always finds room for its output. At most one vector is held in the queue at a time, so the queue cannot lock up with a vector stuck at its head.

Top module: `vsplit_fifo`

## Requirements
- R1: After reset, and in any cycle in which the queue is empty, out_valid is low. With no entries held, in_ready is high.
- R2: A scalar entry (in_vec low) accepted into an empty queue is presented on the output in the next cycle. It keeps its opcode and registers, and out_elem reads 0.
- R3: A vector entry is never presented on the output. Its element ops appear in ascending element order. Each carries the vector's opcode, out_rd = (in_rd + e) mod 2^RW, out_rs = (in_rs + e) mod 2^RW and out_elem = e, where e counts from 0 up to in_len-1.
- R4: Element e produces an op only when bit e of in_mask is 1. Bit position equals element index.
- R5: One split pass takes place in the cycle a vector sits at the head. It writes at most N element ops behind the current tail, followed by the remainder of the vector. Masked elements do not count toward N. Entries accepted after the pass are therefore issued before the vector's later elements.
- R6: A vector with in_len of 0, or with no enabled element in range, produces no output and is removed from the queue by its pass.
- R7: in_ready is low in any of three cases: a vector is at the head, the queue holds more than DEPTH-N-2 entries, or in_vec is high while a vector is still held.
- R8: While out_valid is high and out_ready is low, out_valid stays high and the output fields do not change.
- R9: A vector of length MVL (32, the register-file size) with a full mask yields exactly MVL ops, touching every destination register once.
- R10: The first element op of a vector accepted into an empty queue is presented two cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted this cycle when in_valid is high |
| in_vec | input | 1 | 1: vector operation, 0: scalar operation |
| in_op | input | OPW (4) | Opcode |
| in_rd | input | RW (5) | Destination register, or base for a vector |
| in_rs | input | RW (5) | Source register, or base for a vector |
| in_len | input | CW (6) | Vector element count, at most MVL; ignored for scalars |
| in_mask | input | MVL (32) | Predicate, bit e enables element e; ignored for scalars |
| out_valid | output | 1 | A scalar op is presented |
| out_ready | input | 1 | Consumer takes the presented op |
| out_op | output | OPW (4) | Opcode of the issued op |
| out_rd | output | RW (5) | Destination register of the issued op |
| out_rs | output | RW (5) | Source register of the issued op |
| out_elem | output | IW (5) | Element index, 0 for plain scalars |

## Verification
A scalar is due at the output one clock after acceptance. A vector spends one clock at the head for its split pass, so its first element is due two clocks after acceptance. Each later pass costs one further clock at the head, and in that clock in_ready must be low. The bench drives inputs on the falling edge and samples one time unit later. It advances a reference queue once per cycle by these rules: a split if a vector is at its head, otherwise a compare and pop on handshake, then an append on acceptance. Every output, every in_ready value and every idle cycle is compared in exactly the cycle it is due.

// File: rtl/vsf_pkg.sv
package vsf_pkg;
  localparam int OPW = 4;                 // opcode width
  localparam int RW  = 5;                 // register number width
  localparam int MVL = 32;                // max elements, covers the whole register file
  localparam int IW  = $clog2(MVL);       // element index width
  localparam int CW  = $clog2(MVL + 1);   // element count width

  typedef struct packed {
    logic           vec;   // 1: vector entry awaiting a split pass
    logic [OPW-1:0] op;
    logic [RW-1:0]  rd;
    logic [RW-1:0]  rs;
    logic [IW-1:0]  idx;   // next element (vector) or element tag (scalar)
    logic [CW-1:0]  cnt;   // elements still to scan (vector only)
    logic [MVL-1:0] mask;  // predicate by absolute element index
  } vsf_ent_t;
endpackage

// File: rtl/vsf_split.sv
module vsf_split
  import vsf_pkg::*;
#(
  parameter int N  = 4,
  parameter int NW = $clog2(N + 2)
) (
  input  vsf_ent_t        head,
  output vsf_ent_t        wr_ent [N+1],
  output logic [NW-1:0]   wr_num,
  output logic            last
);
  logic [MVL-1:0] win;
  logic [NW-1:0]  acc;
  logic           full;
  logic [CW-1:0]  used;
  logic [CW-1:0]  rem;

  function automatic vsf_ent_t elem_op(vsf_ent_t v, logic [IW-1:0] e);
    vsf_ent_t s;
    s      = '0;
    s.op   = v.op;
    s.rd   = v.rd + RW'(e);
    s.rs   = v.rs + RW'(e);
    s.idx  = e;
    return s;
  endfunction

  always_comb begin
    win  = head.mask >> head.idx;
    acc  = '0;
    full = 1'b0;
    used = head.cnt;
    for (int k = 0; k <= N; k++) wr_ent[k] = '0;
    for (int j = 0; j < MVL; j++) begin
      if (!full && (j < int'(head.cnt)) && win[j]) begin
        wr_ent[acc] = elem_op(head, IW'(int'(head.idx) + j));
        acc = acc + NW'(1);
        if (int'(acc) == N) begin
          full = 1'b1;
          used = CW'(j + 1);
        end
      end
    end
    rem    = head.cnt - used;
    wr_num = acc;
    last   = (rem == '0);
    if (!last) begin
      wr_ent[acc]     = head;
      wr_ent[acc].idx = head.idx + IW'(used);
      wr_ent[acc].cnt = rem;
      wr_num          = acc + NW'(1);
    end
  end
endmodule

// File: rtl/vsf_ring.sv
module vsf_ring
  import vsf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WN    = 5,
  parameter int NW    = 3,
  parameter int AW    = $clog2(DEPTH),
  parameter int CNW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NW-1:0]  wr_num,
  input  vsf_ent_t       wr_ent [WN],
  input  logic           pop,
  output vsf_ent_t       head,
  output logic [CNW-1:0] count
);
  vsf_ent_t       mem [DEPTH];
  logic [AW-1:0]  rd_ptr, rd_ptr_d, wr_ptr, wr_ptr_d;
  logic [CNW-1:0] count_d;

  function automatic logic [AW-1:0] adv(logic [AW-1:0] p, int unsigned k);
    return AW'((32'(p) + k) % DEPTH);
  endfunction

  always_comb begin
    wr_ptr_d = adv(wr_ptr, int'(wr_num));
    rd_ptr_d = pop ? adv(rd_ptr, 1) : rd_ptr;
    count_d  = count + CNW'(wr_num) - CNW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_ptr_d;
      wr_ptr <= wr_ptr_d;
      count  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < WN; k++) begin
      if (k < int'(wr_num)) mem[adv(wr_ptr, k)] <= wr_ent[k];
    end
  end

  assign head = mem[rd_ptr];
endmodule

// File: rtl/vsplit_fifo.sv
module vsplit_fifo
  import vsf_pkg::*;
#(
  parameter int N     = 4,
  parameter int DEPTH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           in_vec,
  input  logic [OPW-1:0] in_op,
  input  logic [RW-1:0]  in_rd,
  input  logic [RW-1:0]  in_rs,
  input  logic [CW-1:0]  in_len,
  input  logic [MVL-1:0] in_mask,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [OPW-1:0] out_op,
  output logic [RW-1:0]  out_rd,
  output logic [RW-1:0]  out_rs,
  output logic [IW-1:0]  out_elem
);
  localparam int NW    = $clog2(N + 2);
  localparam int CNW   = $clog2(DEPTH + 1);
  localparam int ADMIT = DEPTH - N - 2;   // highest occupancy that still admits input
  localparam int ROOM  = DEPTH - N - 1;   // highest occupancy that still allows a pass

  vsf_ent_t       head, in_ent;
  vsf_ent_t       sp_ent [N+1];
  vsf_ent_t       wr_ent [N+1];
  logic [NW-1:0]  sp_num, wr_num;
  logic           sp_last;
  logic [CNW-1:0] count;
  logic           head_vec, split_go, push, issue, pop;
  logic           vec_q, vec_q_d;

  vsf_split #(.N(N), .NW(NW)) u_split (
    .head   (head),
    .wr_ent (sp_ent),
    .wr_num (sp_num),
    .last   (sp_last)
  );

  vsf_ring #(.DEPTH(DEPTH), .WN(N + 1), .NW(NW)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_num (wr_num),
    .wr_ent (wr_ent),
    .pop    (pop),
    .head   (head),
    .count  (count)
  );

  assign head_vec  = (count != '0) && head.vec;
  assign split_go  = head_vec && (count <= CNW'(ROOM));
  assign out_valid = (count != '0) && !head.vec;
  assign in_ready  = !head_vec && (count <= CNW'(ADMIT)) && !(in_vec && vec_q);
  assign push      = in_valid && in_ready;
  assign issue     = out_valid && out_ready;
  assign pop       = split_go || issue;

  always_comb begin
    in_ent      = '0;
    in_ent.vec  = in_vec;
    in_ent.op   = in_op;
    in_ent.rd   = in_rd;
    in_ent.rs   = in_rs;
    in_ent.cnt  = in_vec ? in_len  : '0;
    in_ent.mask = in_vec ? in_mask : '0;
  end

  // write port: a split pass owns it; otherwise one accepted input
  always_comb begin
    for (int k = 0; k <= N; k++) wr_ent[k] = '0;
    wr_num = '0;
    if (split_go) begin
      for (int k = 0; k <= N; k++) wr_ent[k] = sp_ent[k];
      wr_num = sp_num;
    end else if (push) begin
      wr_ent[0] = in_ent;
      wr_num    = NW'(1);
    end
  end

  always_comb begin
    vec_q_d = vec_q;
    if (split_go && sp_last) vec_q_d = 1'b0;
    if (push && in_vec)      vec_q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= 1'b0;
    else        vec_q <= vec_q_d;
  end

  assign out_op   = head.op;
  assign out_rd   = head.rd;
  assign out_rs   = head.rs;
  assign out_elem = head.idx;
endmodule

// File: rtl/vsplit_fifo_chk.sv
module vsplit_fifo_chk
  import vsf_pkg::*;
#(
  parameter int N     = 4,
  parameter int DEPTH = 16,
  parameter int CNW   = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_ready,
  input logic           in_vec,
  input logic           out_valid,
  input logic           out_ready,
  input logic [OPW-1:0] out_op,
  input logic [RW-1:0]  out_rd,
  input logic [RW-1:0]  out_rs,
  input logic [IW-1:0]  out_elem,
  input logic [CNW-1:0] count,
  input logic           head_vec,
  input logic           split_go,
  input logic           vec_q
);
  a_r1_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !out_valid);

  a_r3_vector_not_issued: assert property (@(posedge clk) disable iff (!rst_n)
    head_vec |-> !out_valid);

  a_r5_pass_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    head_vec |-> split_go);

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNW'(DEPTH));

  a_r7_split_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    split_go |-> !in_ready);

  a_r7_admit_limit: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (count <= CNW'(DEPTH - N - 2)));

  a_r7_single_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_q && in_vec) |-> !in_ready);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_rd)
                                   && $stable(out_rs) && $stable(out_elem)));
endmodule

bind vsplit_fifo vsplit_fifo_chk #(.N(N), .DEPTH(DEPTH), .CNW(CNW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .in_vec    (in_vec),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_op    (out_op),
  .out_rd    (out_rd),
  .out_rs    (out_rs),
  .out_elem  (out_elem),
  .count     (count),
  .head_vec  (head_vec),
  .split_go  (split_go),
  .vec_q     (vec_q)
);

// File: tb/vsplit_fifo_bench.sv
module vsplit_fifo_bench;
  import vsf_pkg::*;

  localparam int CLK_P = 10;
  localparam int N     = 4;
  localparam int DEPTH = 16;

  logic           clk, rst_n;
  logic           in_valid, in_ready, in_vec, out_valid, out_ready;
  logic [OPW-1:0] in_op, out_op;
  logic [RW-1:0]  in_rd, in_rs, out_rd, out_rs;
  logic [CW-1:0]  in_len;
  logic [MVL-1:0] in_mask;
  logic [IW-1:0]  out_elem;

  vsplit_fifo #(.N(N), .DEPTH(DEPTH)) u_vsplit_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_vec(in_vec),
    .in_op(in_op), .in_rd(in_rd), .in_rs(in_rs), .in_len(in_len), .in_mask(in_mask),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_op(out_op), .out_rd(out_rd), .out_rs(out_rs), .out_elem(out_elem)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  int             n_chk, n_bad, n_iss;
  bit             fin;
  vsf_ent_t       mq[$];
  bit             mfv[$];
  logic [2**RW-1:0] cover_rd;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // reference split: walk elements, honour mask, stop after N enabled ones
  task automatic model_split();
    vsf_ent_t v, s;
    int i, left, made;
    v = mq.pop_front();
    void'(mfv.pop_front());
    i = int'(v.idx); left = int'(v.cnt); made = 0;
    while (left > 0 && made < N) begin
      if (v.mask[i]) begin
        s = '0; s.op = v.op;
        s.rd = RW'((int'(v.rd) + i) % (2**RW));
        s.rs = RW'((int'(v.rs) + i) % (2**RW));
        s.idx = IW'(i);
        mq.push_back(s); mfv.push_back(1'b1);
        made++;
      end
      i++; left--;
    end
    if (left > 0) begin
      v.idx = IW'(i); v.cnt = CW'(left);
      mq.push_back(v); mfv.push_back(1'b1);
    end
  endtask

  task automatic step();
    bit hv, hasv, exp_rdy;
    string tg;
    vsf_ent_t e;
    hv = (mq.size() > 0) && mq[0].vec;
    hasv = 1'b0;
    foreach (mq[k]) if (mq[k].vec) hasv = 1'b1;
    exp_rdy = !hv && (mq.size() <= DEPTH - N - 2) && !(in_vec && hasv);
    chk(in_ready == exp_rdy, "R7", "in_ready", int'(in_ready), int'(exp_rdy));
    if (hv) begin
      chk(!out_valid, "R3", "out_valid while vector at head", int'(out_valid), 0);
      model_split();
    end else if (mq.size() > 0) begin
      tg = mfv[0] ? "R3,R4,R5" : "R2";
      chk(out_valid == 1'b1, tg, "out_valid", int'(out_valid), 1);
      chk(out_op == mq[0].op, tg, "out_op", int'(out_op), int'(mq[0].op));
      chk(out_rd == mq[0].rd, tg, "out_rd", int'(out_rd), int'(mq[0].rd));
      chk(out_rs == mq[0].rs, tg, "out_rs", int'(out_rs), int'(mq[0].rs));
      chk(out_elem == mq[0].idx, tg, "out_elem", int'(out_elem), int'(mq[0].idx));
      if (out_ready) begin
        void'(mq.pop_front()); void'(mfv.pop_front());
        n_iss++; cover_rd[out_rd] = 1'b1;
      end
    end else begin
      chk(!out_valid, "R1", "out_valid on empty queue", int'(out_valid), 0);
    end
    if (in_valid && in_ready) begin
      e = '0; e.vec = in_vec; e.op = in_op; e.rd = in_rd; e.rs = in_rs;
      if (in_vec) begin e.cnt = in_len; e.mask = in_mask; end
      mq.push_back(e); mfv.push_back(1'b0);
    end
  endtask

  task automatic cyc(bit iv, bit ivec, logic [OPW-1:0] op, logic [RW-1:0] rd,
                     logic [RW-1:0] rs, logic [CW-1:0] len, logic [MVL-1:0] mask, bit ordy);
    @(negedge clk);
    in_valid = iv; in_vec = ivec; in_op = op; in_rd = rd; in_rs = rs;
    in_len = len; in_mask = mask; out_ready = ordy;
    #1;
    step();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(0, 0, '0, '0, '0, '0, '0, 1);
  endtask

  task automatic drain();
    for (int k = 0; k < 200 && mq.size() > 0; k++) idle(1);
    idle(1);
  endtask

  initial begin
    int base;
    logic [OPW-1:0] c_op; logic [RW-1:0] c_rd, c_rs; logic [IW-1:0] c_el;
    n_chk = 0; n_bad = 0; n_iss = 0; fin = 0; cover_rd = '0;
    rst_n = 1'b0; in_valid = 0; in_vec = 0; in_op = '0; in_rd = '0; in_rs = '0;
    in_len = '0; in_mask = '0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready, "R1", "in_ready after reset", int'(in_ready), 1);

    // R2: scalar into empty queue, due one cycle later
    cyc(1, 0, 4'h9, 5'd7, 5'd12, '0, '0, 1);
    idle(2);

    // R3, R10: vector with register wrap, first element due two cycles later
    base = n_iss;
    cyc(1, 1, 4'h3, 5'd30, 5'd2, 6'd8, '1, 1);
    drain();
    chk(n_iss - base == 8, "R3", "element count", n_iss - base, 8);

    // R4: alternating mask
    base = n_iss;
    cyc(1, 1, 4'h5, 5'd1, 5'd4, 6'd10, 32'h5555_5555, 1);
    drain();
    chk(n_iss - base == 5, "R4", "enabled elements", n_iss - base, 5);

    // R6: empty and fully masked vectors
    base = n_iss;
    cyc(1, 1, 4'h1, 5'd0, 5'd0, 6'd0, '1, 1);
    idle(2);
    cyc(1, 1, 4'h2, 5'd0, 5'd0, 6'd20, '0, 1);
    idle(2);
    chk(n_iss - base == 0, "R6", "ops from empty vectors", n_iss - base, 0);
    cyc(1, 1, 4'h2, 5'd3, 5'd3, 6'd3, '1, 1);
    drain();
    chk(n_iss - base == 3, "R6", "vector after empty ones", n_iss - base, 3);

    // R5: long vector with scalars pushed behind it every cycle
    cyc(1, 1, 4'h6, 5'd0, 5'd16, 6'd12, 32'hFFF, 1);
    for (int k = 0; k < 10; k++) cyc(1, 0, 4'hA, RW'(k), RW'(k), '0, '0, 1);
    drain();

    // R8: stall with out_ready low
    for (int k = 0; k < 3; k++) cyc(1, 0, 4'hC, RW'(k + 20), 5'd1, '0, '0, 0);
    @(negedge clk); in_valid = 0; out_ready = 0; #1;
    c_op = out_op; c_rd = out_rd; c_rs = out_rs; c_el = out_elem; step();
    for (int k = 0; k < 4; k++) begin
      cyc(0, 0, '0, '0, '0, '0, '0, 0);
      chk(out_valid && out_op == c_op && out_rd == c_rd && out_rs == c_rs && out_elem == c_el,
          "R8", "held output", int'(out_rd), int'(c_rd));
    end
    drain();

    // R9: full-length vector covers every register
    base = n_iss; cover_rd = '0;
    cyc(1, 1, 4'h7, 5'd0, 5'd0, CW'(MVL), '1, 1);
    drain();
    chk(n_iss - base == MVL, "R9", "full-length ops", n_iss - base, MVL);
    chk(&cover_rd, "R9", "registers covered", $countones(cover_rd), 2**RW);

    // random mix
    void'($urandom(32'd20240517));
    for (int k = 0; k < 4000; k++) begin
      cyc(($urandom % 10) < 6, ($urandom % 10) < 3, OPW'($urandom), RW'($urandom),
          RW'($urandom), CW'($urandom_range(0, MVL)), $urandom, ($urandom % 10) < 7);
    end
    drain();
    chk(mq.size() == 0, "R1", "reference queue drained", mq.size(), 0);

    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule